// File: doc/BRIEF.md
# Two-Channel DMA Control/Status Register File

This block is the software-facing register file of a simple, single-buffer DMA engine that has two channels. The fetch channel reads memory and feeds a stream. The store channel takes a stream and writes it to memory. Software reaches the block through an AXI4-Lite slave port. For each channel it can set a run/stop bit, load a 32-bit memory pointer and load a transfer length in bytes. It can also read back a status word.

Writing the length of a channel that is running launches a transfer. The block then drives a one-cycle start pulse to that channel's data mover, together with the stored pointer and length. It waits for the mover's done pulse and folds any error flags that come with it into sticky status bits. Each channel tracks its own running/halted and busy/idle state. The data movers live outside this block.

Top module: `dma_csr_lite`

## Requirements
- R1: After reset every control, pointer and length register reads 0. Each status register reads 0x1 (halted=1, idle=0, no errors), and no start pulse is issued.
- R2: The fetch bank holds control at 0x00, status at 0x04, pointer at 0x18 and length at 0x28. The store bank holds the same registers at 0x30, 0x34, 0x48 and 0x58. Address bits [1:0] are ignored. Reads and writes to these word addresses respond 2'b00. Any other address responds 2'b11, and a read from it returns 0.
- R3: Control bit 0 is run. It reads back as written. While run=1 the status halted bit (bit 0) reads 0.
- R4: A length write to a running channel that is not busy issues exactly one start pulse. During that pulse the channel's address and length outputs carry the new values. The status then reads halted=0, idle=0.
- R5: A done pulse from a busy channel's mover ends the transfer. With run still 1, the status reads halted=0 and idle=1 (bit 1).
- R6: A length write while run=0 stores the value (length is 26 bits, and upper bits read 0) but issues no start.
- R7: While a channel is busy, writes to its pointer and length registers are ignored: both the readback and the outputs are unchanged, and no second start is issued.
- R8: Clearing run during a transfer keeps halted=0 until the done pulse. After the done pulse the status reads halted=1 and idle=1.
- R9: The error flags delivered with a done pulse (internal, slave, decode) set status bits 4, 5 and 6. Those bits stay set through later transfers and clear only on reset.
- R10: Byte strobes select which bytes of a pointer or length register a write updates.
- R11: The two channels are independent. Activity on one never alters the other channel's registers, status or start output.
- R12: A write response is raised only after both address and data are accepted. It holds BVALID and BRESP steady until BREADY is high.
- R13: Status registers are read-only. A write to them responds OK and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (00 OK, 11 decode error) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (00 OK, 11 decode error) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| rch_start | output | 1 | Fetch-channel start pulse |
| rch_addr | output | PTR_W | Fetch-channel source pointer |
| rch_len | output | LEN_W | Fetch-channel byte count |
| rch_done | input | 1 | Fetch-channel completion pulse |
| rch_err | input | 3 | Fetch-channel errors with done: [0] internal, [1] slave, [2] decode |
| wch_start | output | 1 | Store-channel start pulse |
| wch_addr | output | PTR_W | Store-channel destination pointer |
| wch_len | output | LEN_W | Store-channel byte count |
| wch_done | input | 1 | Store-channel completion pulse |
| wch_err | input | 3 | Store-channel errors with done: [0] internal, [1] slave, [2] decode |

## Verification
A corrupted busy flag shows up at once: a second start pulse appears on the next length write, or a pointer write lands mid-transfer and is visible on the address output. Either way it is visible within one bus write. A halted or idle flag that is wrong appears in the very next status read after the triggering write or done pulse. A decode fault shows up as a wrong response code or stray readback in the full address sweeps. A lost sticky error bit is exposed by the status read that follows the next clean transfer.

// File: rtl/dma_csr_lite.sv
module dma_csr_lite #(
  parameter int ADDR_W = 7,
  parameter int PTR_W  = 32,
  parameter int LEN_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              rch_start,
  output logic [PTR_W-1:0]  rch_addr,
  output logic [LEN_W-1:0]  rch_len,
  input  logic              rch_done,
  input  logic [2:0]        rch_err,
  output logic              wch_start,
  output logic [PTR_W-1:0]  wch_addr,
  output logic [LEN_W-1:0]  wch_len,
  input  logic              wch_done,
  input  logic [2:0]        wch_err
);

  localparam int NCH     = 2;
  localparam int BANK1   = 'h30;
  localparam int OFF_CTL = 'h00;
  localparam int OFF_STS = 'h04;
  localparam int OFF_PTR = 'h18;
  localparam int OFF_LEN = 'h28;
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_STS = 2'd1;
  localparam logic [1:0] SEL_PTR = 2'd2;
  localparam logic [1:0] SEL_LEN = 2'd3;
  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_DEC = 2'b11;

  // decode result: {hit, channel, select[1:0]}
  function automatic logic [3:0] decode(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] w, off;
    logic hi;
    w   = {a[ADDR_W-1:2], 2'b00};
    hi  = (w >= ADDR_W'(BANK1));
    off = hi ? w - ADDR_W'(BANK1) : w;
    case (off)
      ADDR_W'(OFF_CTL): return {1'b1, hi, SEL_CTL};
      ADDR_W'(OFF_STS): return {1'b1, hi, SEL_STS};
      ADDR_W'(OFF_PTR): return {1'b1, hi, SEL_PTR};
      ADDR_W'(OFF_LEN): return {1'b1, hi, SEL_LEN};
      default:          return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  logic              aw_got, w_got, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0] aw_q;
  logic [31:0]       w_q, rdata_q;
  logic [3:0]        strb_q;
  logic [1:0]        bresp_q, rresp_q;
  logic [3:0]        wdec, rdec;
  logic              wr_fire;

  logic [NCH-1:0]    run, halted, idle, busy, start, go, wsel, fin, done_in;
  logic [PTR_W-1:0]  ptr [NCH];
  logic [LEN_W-1:0]  len [NCH];
  logic [2:0]        errs [NCH];
  logic [2:0]        err_in [NCH];
  logic [31:0]       ptr_nx [NCH];
  logic [31:0]       len_nx [NCH];
  logic [31:0]       rword;

  assign s_awready = ~aw_got & ~bvalid_q;
  assign s_wready  = ~w_got & ~bvalid_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = bresp_q;
  assign s_arready = ~rvalid_q;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = rresp_q;

  assign wdec    = decode(aw_q);
  assign rdec    = decode(s_araddr);
  assign wr_fire = aw_got & w_got & ~bvalid_q;

  assign done_in   = {wch_done, rch_done};
  assign err_in[0] = rch_err;
  assign err_in[1] = wch_err;

  assign rch_start = start[0];
  assign rch_addr  = ptr[0];
  assign rch_len   = len[0];
  assign wch_start = start[1];
  assign wch_addr  = ptr[1];
  assign wch_len   = len[1];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      wsel[c]   = wr_fire & wdec[3] & (wdec[2] == c[0]);
      go[c]     = wsel[c] & (wdec[1:0] == SEL_LEN) & run[c] & ~busy[c];
      fin[c]    = done_in[c] & busy[c];
      ptr_nx[c] = merge(32'(ptr[c]), w_q, strb_q);
      len_nx[c] = merge(32'(len[c]), w_q, strb_q);
    end
  end

  always_comb begin
    rword = '0;
    case (rdec[1:0])
      SEL_CTL: rword = {31'b0, run[rdec[2]]};
      SEL_STS: rword = {25'b0, errs[rdec[2]], 2'b00, idle[rdec[2]], halted[rdec[2]]};
      SEL_PTR: rword = 32'(ptr[rdec[2]]);
      SEL_LEN: rword = 32'(len[rdec[2]]);
      default: rword = '0;
    endcase
    if (!rdec[3]) rword = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_got   <= 1'b0;
      w_got    <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      strb_q   <= '0;
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OK;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_got <= 1'b1;
        aw_q   <= s_awaddr;
      end
      if (s_wvalid && s_wready) begin
        w_got  <= 1'b1;
        w_q    <= s_wdata;
        strb_q <= s_wstrb;
      end
      if (wr_fire) begin
        aw_got   <= 1'b0;
        w_got    <= 1'b0;
        bvalid_q <= 1'b1;
        bresp_q  <= wdec[3] ? RESP_OK : RESP_DEC;
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      rresp_q  <= RESP_OK;
    end else if (s_arvalid && s_arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rword;
      rresp_q  <= rdec[3] ? RESP_OK : RESP_DEC;
    end else if (rvalid_q && s_rready) begin
      rvalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      halted <= '1;
      idle   <= '0;
      busy   <= '0;
      start  <= '0;
      for (int c = 0; c < NCH; c++) begin
        ptr[c]  <= '0;
        len[c]  <= '0;
        errs[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        start[c] <= go[c];
        if (wsel[c] && wdec[1:0] == SEL_CTL && strb_q[0]) run[c] <= w_q[0];
        if (wsel[c] && wdec[1:0] == SEL_PTR && !busy[c]) ptr[c] <= ptr_nx[c][PTR_W-1:0];
        if (wsel[c] && wdec[1:0] == SEL_LEN && !busy[c]) len[c] <= len_nx[c][LEN_W-1:0];
        if (go[c]) begin
          busy[c] <= 1'b1;
          idle[c] <= 1'b0;
        end else if (fin[c]) begin
          busy[c] <= 1'b0;
          idle[c] <= 1'b1;
          errs[c] <= errs[c] | err_in[c];
        end
        halted[c] <= ~run[c] & ~busy[c];
      end
    end
  end

  // R12
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));

  // R12
  bresp_after_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> $past(aw_got) && $past(w_got));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R4
      start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start[c] |=> !start[c]);
      // R4
      start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start[c] |-> busy[c] && !idle[c]);
      // R7
      ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[c] |=> $stable(ptr[c]) && $stable(len[c]));
      // R8
      busy_not_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[c] |-> !halted[c]);
      // R9
      err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        errs[c] != 3'b000 |=> (errs[c] | $past(errs[c])) == errs[c]);
    end
  endgenerate

endmodule

// File: tb/dma_csr_lite_test.sv
module dma_csr_lite_test;
  localparam int AW = 7;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic rch_start, wch_start, rch_done = 0, wch_done = 0;
  logic [2:0] rch_err = 0, wch_err = 0;
  logic [31:0] rch_addr, wch_addr;
  logic [25:0] rch_len, wch_len;

  int tests = 0, fails = 0;
  int n_rs = 0, n_ws = 0;
  logic [31:0] cap_ra = 0, cap_wa = 0;
  logic [25:0] cap_rl = 0, cap_wl = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_csr_lite uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .rch_start(rch_start), .rch_addr(rch_addr), .rch_len(rch_len),
    .rch_done(rch_done), .rch_err(rch_err),
    .wch_start(wch_start), .wch_addr(wch_addr), .wch_len(wch_len),
    .wch_done(wch_done), .wch_err(wch_err)
  );

  always @(posedge clk) begin
    if (rch_start) begin n_rs++; cap_ra = rch_addr; cap_rl = rch_len; end
    if (wch_start) begin n_ws++; cap_wa = wch_addr; cap_wl = wch_len; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be,
                    input int hold, output logic [1:0] resp);
    @(negedge clk);
    awaddr = AW'(a); wdata = d; wstrb = be; awvalid = 1; wvalid = 1;
    while (awvalid || wvalid) begin
      bit ah, wh;
      ah = awvalid && awready;
      wh = wvalid && wready;
      @(negedge clk);
      if (ah) awvalid = 0;
      if (wh) wvalid = 0;
    end
    while (!bvalid) @(negedge clk);
    resp = bresp;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(bvalid && bresp == resp, "R12 bvalid/bresp held", {30'b0, bresp}, {30'b0, resp});
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    araddr = AW'(a); arvalid = 1;
    while (arvalid) begin
      bit h;
      h = arready;
      @(negedge clk);
      if (h) arvalid = 0;
    end
    while (!rvalid) @(negedge clk);
    d = rdata; resp = rresp;
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic done_pulse(input bit ch, input logic [2:0] e);
    @(negedge clk);
    if (ch) begin wch_done = 1; wch_err = e; end
    else begin rch_done = 1; rch_err = e; end
    @(negedge clk);
    rch_done = 0; wch_done = 0; rch_err = 0; wch_err = 0;
  endtask

  function automatic bit mapped(int a);
    int o;
    o = (a >= 'h30) ? a - 'h30 : a;
    return o == 0 || o == 4 || o == 'h18 || o == 'h28;
  endfunction

  function automatic logic [31:0] pat(int a);
    return {8'(a), 8'h3C, 8'(a) ^ 8'hFF, 8'hA4};
  endfunction

  function automatic logic [31:0] exp_fill(int a);
    int o;
    o = (a >= 'h30) ? a - 'h30 : a;
    if (!mapped(a)) return 0;
    case (o)
      0: return 0;
      4: return 1;
      'h18: return pat(a);
      default: return pat(a) & 32'h03FF_FFFF;
    endcase
  endfunction

  task automatic rchk(input int a, input logic [31:0] exp, input string req);
    logic [31:0] d; logic [1:0] r;
    rd(a, d, r);
    chk(d == exp && r == 2'b00, req, d, exp);
  endtask

  task automatic wok(input int a, input logic [31:0] d, input string req);
    logic [1:0] r;
    wr(a, d, 4'hF, 0, r);
    chk(r == 2'b00, req, {30'b0, r}, 0);
  endtask

  initial begin
    logic [31:0] d; logic [1:0] r;
    do_reset();

    // R1, R2: reset sweep over every word address
    for (int a = 0; a < 128; a += 4) begin
      rd(a + (a % 3), d, r);
      if (mapped(a))
        chk(d == ((a % 48) == 4 ? 32'h1 : 32'h0) && r == 2'b00, "R1 reset value", d,
            (a % 48) == 4 ? 32'h1 : 32'h0);
      else
        chk(d == 0 && r == 2'b11, "R2 unmapped read", {r, d[29:0]}, 32'hC000_0000);
    end
    chk(n_rs == 0 && n_ws == 0, "R1 no start after reset", n_rs + n_ws, 0);

    // R2, R6, R13: fill every address while stopped, then read back
    for (int a = 0; a < 128; a += 4) begin
      wr(a, pat(a), 4'hF, (a == 8) ? 3 : 0, r);
      chk(r == (mapped(a) ? 2'b00 : 2'b11), "R2 write response", {30'b0, r},
          mapped(a) ? 0 : 3);
    end
    for (int a = 0; a < 128; a += 4) begin
      rd(a, d, r);
      chk(d == exp_fill(a) && r == (mapped(a) ? 2'b00 : 2'b11), "R6 R13 fill readback", d, exp_fill(a));
    end
    chk(n_rs == 0 && n_ws == 0, "R6 no start while stopped", n_rs + n_ws, 0);
    chk(rch_addr == pat('h18) && rch_len == 26'(pat('h28)), "R6 outputs follow registers",
        rch_addr, pat('h18));

    // R10: byte strobes
    wr('h48, 32'hFFFF_FFFF, 4'b0101, 0, r);
    rchk('h48, pat('h48) | 32'h00FF_00FF, "R10 byte strobe merge");
    wr('h58, 32'h0000_0000, 4'b1000, 2, r);
    rchk('h58, pat('h58) & 32'h00FF_FFFF, "R10 top byte strobe");

    // R3, R4: run fetch channel and launch
    wok('h00, 1, "R3 ctrl write");
    rchk('h00, 1, "R3 run readback");
    rchk('h04, 0, "R3 running status");
    wok('h18, 32'h1000_0040, "R4 ptr write");
    wok('h28, 32'h0000_0100, "R4 len write");
    chk(n_rs == 1 && cap_ra == 32'h1000_0040 && cap_rl == 26'h100, "R4 start with values", cap_ra, 32'h1000_0040);
    chk(n_ws == 0, "R11 store channel quiet", n_ws, 0);
    rchk('h04, 0, "R4 busy status");

    // R7: writes ignored while busy
    wok('h18, 32'hDEAD_BEEF, "R7 ptr write accepted");
    wok('h28, 32'h55, "R7 len write accepted");
    rchk('h18, 32'h1000_0040, "R7 ptr unchanged");
    rchk('h28, 32'h100, "R7 len unchanged");
    chk(n_rs == 1 && rch_len == 26'h100, "R7 no second start", n_rs, 1);

    // R5
    done_pulse(0, 3'b000);
    rchk('h04, 32'h2, "R5 done status");
    rchk('h34, 32'h1, "R11 store status untouched");

    // R9, R11: store channel with errors
    wok('h30, 1, "R11 store run");
    wok('h48, 32'h2000_0000, "R11 store ptr");
    wok('h58, 32'h40, "R11 store len");
    chk(n_ws == 1 && cap_wa == 32'h2000_0000 && cap_wl == 26'h40, "R11 store start", cap_wa, 32'h2000_0000);
    done_pulse(1, 3'b101);
    rchk('h34, 32'h52, "R9 error bits latched");
    wok('h58, 32'h80, "R9 second launch");
    chk(n_ws == 2, "R9 second start", n_ws, 2);
    done_pulse(1, 3'b010);
    rchk('h34, 32'h72, "R9 errors accumulate");
    wok('h58, 32'h80, "R9 third launch");
    done_pulse(1, 3'b000);
    rchk('h34, 32'h72, "R9 errors sticky");
    rchk('h04, 32'h2, "R11 fetch status untouched");
    wok('h34, 32'h0, "R13 status write");
    rchk('h34, 32'h72, "R13 status read-only");

    // R8: stop mid-transfer
    wok('h28, 32'h20, "R8 launch");
    chk(n_rs == 2, "R8 start", n_rs, 2);
    wok('h00, 0, "R8 stop");
    rchk('h04, 0, "R8 halted deferred");
    done_pulse(0, 3'b000);
    rchk('h04, 32'h3, "R8 halted after done");
    wok('h28, 32'h44, "R6 len while halted");
    chk(n_rs == 2, "R6 no start while halted", n_rs, 2);
    rchk('h28, 32'h44, "R6 len stored");

    // R9: reset clears errors
    do_reset();
    rchk('h34, 32'h1, "R9 reset clears errors");
    rchk('h28, 32'h0, "R1 len cleared");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule